// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an external host controller to an on-chip register file. A strap pin, sampled while reset is held, picks one of two host bus types for the whole session. In parallel mode the host drives a multiplexed 8-bit bus. An address latch enable strobe marks the address phase. Active-low write and read strobes mark the data phase. A separate device-select input qualifies each cycle. In serial mode the top three bus pins are used as a serial clock, a bidirectional data line and an active-low chip select.

All host signals are asynchronous to the core clock. They pass through two-flop synchronizers, and every strobe edge is detected in the core clock domain. Toward the core the block presents a register address, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data return bus. The register file must hold read data stable for as long as the address is unchanged.

Top module: `hbus_port`

## Requirements
- R1: `cfg_serial` is captured into the mode register on every clock edge while `rst_n` is low, and keeps that value after reset until the next reset. Value 0 selects parallel mode and value 1 selects serial mode.
- R2: In parallel mode, the synchronized `host_ad` value is latched as the register address on the falling edge of `host_ale`. `host_dsel` is latched at the same moment.
- R3: In parallel mode with the latched select high, a rising edge of `host_wr_n` gives exactly one cycle of `reg_we`. `reg_wdata` carries the byte that was on `host_ad` while the strobe was low.
- R4: In parallel mode with the latched select low, no write strobe or read strobe is issued and the bus is never driven.
- R5: In parallel mode with the latched select high, a falling edge of `host_rd_n` gives one cycle of `reg_re`. The returned byte is then driven on `host_ad_o` with `host_ad_oe` = 8'hFF. The drive is removed within two cycles of the synchronized read strobe going high.
- R6: The serial frame is 16 bits long, sent MSB first and sampled on rising edges of the serial clock. It carries a direction bit (1 = read, 0 = write), then a 7-bit address, then 8 data bits. The pins are: serial clock on `host_ad_i[7]`, data on bit 6, chip select (active low) on bit 5.
- R7: A serial write issues one `reg_we` after the 16th rising clock edge. The address is zero-extended to 8 bits.
- R8: A serial read issues `reg_re` after the 8th rising edge. The read byte, MSB first, is driven on `host_ad_o[6]`, updated on each following falling edge, with `host_ad_oe` = 8'h40. The drive is released after the chip select goes high.
- R9: Raising the chip select before the 16th rising edge abandons the frame with no write. The next frame starts from its first bit.
- R10: In serial mode the parallel strobes `host_ale`, `host_wr_n` and `host_rd_n` are ignored. They cause no write and no bus drive.
- R11: `reg_we` and `reg_re` are never asserted in the same cycle.
- R12: After reset, `reg_we`, `reg_re` and `host_ad_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_serial | input | 1 | Mode strap, sampled during reset |
| host_ad_i | input | 8 | Host bus input value (address/data, or serial pins) |
| host_ad_o | output | 8 | Value the block drives onto the host bus |
| host_ad_oe | output | 8 | Per-bit drive enable for the host bus |
| host_dsel | input | 1 | High-order select that qualifies a parallel cycle |
| host_ale | input | 1 | Address latch enable |
| host_wr_n | input | 1 | Write strobe, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| reg_addr | output | 8 | Register address toward the core |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Register read data from the core |

## Verification
The parallel front end is swept over all 256 addresses, each written with an arithmetic pattern and then read back. This tells apart address-latch errors, data-path errors and strobe-edge errors. Writes and reads with device select low check that a disqualified cycle leaves the register file and the bus alone. The serial front end is swept over all 128 addresses with a second pattern, so bit order, direction decoding and falling-edge drive of read data are each exposed. A truncated frame, parallel strobes toggled in serial mode, and a strap changed after reset cover abort, mode isolation and mode holding.

// File: rtl/hbus_pkg.sv
// Shared definitions for the host register port.
// Assumes an 8-bit-class bus; the widths are set by the users of the package.
package hbus_pkg;
    typedef enum logic {
        HB_PARALLEL = 1'b0,
        HB_SERIAL   = 1'b1
    } hb_mode_e;
endpackage

// File: rtl/hbus_sync.sv
// Two-flop synchronizer for a vector of asynchronous host signals.
// Assumes each bit is independent; the reset value matches the idle pin level.
module hbus_sync #(
    parameter int          W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the core clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbus_par_fe.sv
// Parallel front end: multiplexed address/data with latch enable and strobes.
// Assumes synchronized inputs and strobes at least four core cycles wide.
// Read data is captured one cycle after reg_re; the core holds it stable for that cycle.
module hbus_par_fe #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] ad_s,
    input  logic          ale_s,
    input  logic          wr_s,
    input  logic          rd_s,
    input  logic          sel_s,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re,
    output logic [DW-1:0] drv,
    output logic          oe
);
    logic ale_q, wr_q, rd_q, sel_lat, re_q;

    // Edge detection, address latch, strobe generation and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q   <= 1'b0;
            wr_q    <= 1'b1;
            rd_q    <= 1'b1;
            sel_lat <= 1'b0;
            re_q    <= 1'b0;
            addr    <= '0;
            wdata   <= '0;
            we      <= 1'b0;
            re      <= 1'b0;
            drv     <= '0;
            oe      <= 1'b0;
        end else begin
            ale_q <= ale_s;
            wr_q  <= wr_s;
            rd_q  <= rd_s;
            we    <= 1'b0;
            re    <= 1'b0;
            re_q  <= re;
            if (ale_q && !ale_s) begin
                addr    <= ad_s;
                sel_lat <= sel_s;
            end
            if (!wr_s) wdata <= ad_s;
            if (en && sel_lat && !wr_q && wr_s) we <= 1'b1;
            if (en && sel_lat && rd_q && !rd_s) re <= 1'b1;
            if (re_q) begin
                drv <= rdata;
                oe  <= 1'b1;
            end
            if (rd_s || !en) oe <= 1'b0;
        end
    end

    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n) we |=> !we);
    p_no_sel_no_re_r4: assert property (@(posedge clk) disable iff (!rst_n) (!sel_lat && $stable(sel_lat)) |-> !re);
    p_drive_release_r5: assert property (@(posedge clk) disable iff (!rst_n) rd_s |=> !oe);
endmodule

// File: rtl/hbus_ser_fe.sv
// Serial front end: a frame of direction bit, address and data, MSB first.
// Input bits are taken on rising serial clock edges; read data is put out on falling edges.
// Assumes synchronized pins and serial clock half periods of at least four core cycles.
module hbus_ser_fe #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          csn_s,
    input  logic [DW-1:0] rdata,
    output logic [DW-2:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re,
    output logic          sdo,
    output logic          oe
);
    localparam int FW    = 2 * DW;
    localparam int CNT_W = $clog2(FW + 1);
    localparam int IX_W  = $clog2(DW);

    logic [FW-1:0]    sh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] bit_ix;
    logic [DW-1:0]    rbuf;
    logic             sclk_q, rw, re_q, rise, fall;

    assign rise   = sclk_s && !sclk_q;
    assign fall   = !sclk_s && sclk_q;
    assign bit_ix = CNT_W'(FW - 1) - cnt;

    // Frame shifter, bit counter, strobes and read-data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            rbuf   <= '0;
            sclk_q <= 1'b0;
            rw     <= 1'b0;
            re_q   <= 1'b0;
            addr   <= '0;
            wdata  <= '0;
            we     <= 1'b0;
            re     <= 1'b0;
            sdo    <= 1'b0;
            oe     <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            we     <= 1'b0;
            re     <= 1'b0;
            re_q   <= re;
            if (re_q) rbuf <= rdata;
            if (!en || csn_s) begin
                cnt <= '0;
                rw  <= 1'b0;
                oe  <= 1'b0;
            end else begin
                if (rise && cnt < CNT_W'(FW)) begin
                    sh  <= {sh[FW-2:0], sdi_s};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(DW - 1)) begin
                        rw   <= sh[DW-2];
                        addr <= {sh[DW-3:0], sdi_s};
                        re   <= sh[DW-2];
                    end
                    if (cnt == CNT_W'(FW - 1) && !rw) begin
                        wdata <= {sh[DW-2:0], sdi_s};
                        we    <= 1'b1;
                    end
                end
                if (fall && rw && cnt >= CNT_W'(DW) && cnt < CNT_W'(FW)) begin
                    sdo <= rbuf[bit_ix[IX_W-1:0]];
                    oe  <= 1'b1;
                end
            end
        end
    end

    p_we_full_frame_r7: assert property (@(posedge clk) disable iff (!rst_n) we |-> cnt == CNT_W'(FW));
    p_abort_no_we_r9: assert property (@(posedge clk) disable iff (!rst_n) csn_s |=> !we);
    p_drive_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n) oe |-> rw);
endmodule

// File: rtl/hbus_port.sv
// Top of the host register port: the strap selects one front end at reset.
// Assumes the core clock is at least four times faster than the shortest host strobe.
// In serial mode the upper three bus bits carry clock, data and chip select.
module hbus_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_serial,
    input  logic [DW-1:0] host_ad_i,
    output logic [DW-1:0] host_ad_o,
    output logic [DW-1:0] host_ad_oe,
    input  logic          host_dsel,
    input  logic          host_ale,
    input  logic          host_wr_n,
    input  logic          host_rd_n,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    import hbus_pkg::*;

    localparam int SCLK_BIT = DW - 1;
    localparam int SDAT_BIT = DW - 2;
    localparam int CSN_BIT  = DW - 3;
    localparam int SW       = DW + 4;
    localparam logic [DW-1:0] AD_IDLE  = {{(DW-1){1'b0}}, 1'b1} << CSN_BIT;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b0, AD_IDLE};

    hb_mode_e      mode_q;
    logic [SW-1:0] sync_q;
    logic [DW-1:0] ad_s, p_addr, p_wdata, p_drv, s_wdata;
    logic [DW-2:0] s_addr;
    logic          ale_s, wr_s, rd_s, sel_s;
    logic          p_we, p_re, p_oe, s_we, s_re, s_sdo, s_oe;

    // Mode register: follows the strap during reset, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= hb_mode_e'(cfg_serial);
    end

    hbus_sync #(.W(SW), .RST(SYNC_RST)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({host_ale, host_wr_n, host_rd_n, host_dsel, host_ad_i}),
        .q(sync_q)
    );
    assign {ale_s, wr_s, rd_s, sel_s, ad_s} = sync_q;

    hbus_par_fe #(.DW(DW)) par_i (
        .clk(clk), .rst_n(rst_n), .en(mode_q == HB_PARALLEL),
        .ad_s(ad_s), .ale_s(ale_s), .wr_s(wr_s), .rd_s(rd_s), .sel_s(sel_s),
        .rdata(reg_rdata), .addr(p_addr), .wdata(p_wdata),
        .we(p_we), .re(p_re), .drv(p_drv), .oe(p_oe)
    );

    hbus_ser_fe #(.DW(DW)) ser_i (
        .clk(clk), .rst_n(rst_n), .en(mode_q == HB_SERIAL),
        .sclk_s(ad_s[SCLK_BIT]), .sdi_s(ad_s[SDAT_BIT]), .csn_s(ad_s[CSN_BIT]),
        .rdata(reg_rdata), .addr(s_addr), .wdata(s_wdata),
        .we(s_we), .re(s_re), .sdo(s_sdo), .oe(s_oe)
    );

    // Select the active front end toward the core and the pins.
    always_comb begin
        host_ad_o  = '0;
        host_ad_oe = '0;
        if (mode_q == HB_SERIAL) begin
            reg_addr   = {1'b0, s_addr};
            reg_wdata  = s_wdata;
            reg_we     = s_we;
            reg_re     = s_re;
            host_ad_o[SDAT_BIT]  = s_sdo;
            host_ad_oe[SDAT_BIT] = s_oe;
        end else begin
            reg_addr   = p_addr;
            reg_wdata  = p_wdata;
            reg_we     = p_we;
            reg_re     = p_re;
            host_ad_o  = p_drv;
            host_ad_oe = {DW{p_oe}};
        end
    end

    p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> $stable(mode_q));
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re));
    p_serial_no_par_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HB_SERIAL) |-> $countones(host_ad_oe) <= 1);
endmodule

// File: tb/hbus_port_tb.sv
// Bench for the host register port: sweeps both bus modes over the full address space.
module hbus_port_tb_top;
    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic [7:0] host_ad_i = 8'h00;
    logic       host_dsel = 1'b0, host_ale = 1'b0, host_wr_n = 1'b1, host_rd_n = 1'b1;
    logic [7:0] host_ad_o, host_ad_oe, reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic [7:0] mem [256];
    int         wcnt = 0;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    hbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial),
        .host_ad_i(host_ad_i), .host_ad_o(host_ad_o), .host_ad_oe(host_ad_oe),
        .host_dsel(host_dsel), .host_ale(host_ale), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // Register file model on the core side.
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wcnt <= wcnt + 1;
        end
    end

    function automatic logic [7:0] pexp(input int a);
        return 8'(a * 7 + 3);
    endfunction
    function automatic logic [7:0] sexp(input int a);
        return 8'(a * 13 + 5) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        cfg_serial = strap;
        rst_n = 1'b0;
        host_ad_i = strap ? 8'h20 : 8'h00;
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
    endtask

    task automatic par_addr(input logic [7:0] a, input bit sel);
        host_ad_i = a; host_dsel = sel; host_ale = 1'b1; cyc(4);
        host_ale = 1'b0; cyc(4);
    endtask

    task automatic par_write(input logic [7:0] a, input logic [7:0] d, input bit sel);
        par_addr(a, sel);
        host_ad_i = d; host_wr_n = 1'b0; cyc(6);
        host_wr_n = 1'b1; cyc(3);
        host_dsel = 1'b0; cyc(4);
    endtask

    task automatic par_read(input logic [7:0] a, input bit sel,
                            output logic [7:0] got, output logic [7:0] oe_on, output logic [7:0] oe_off);
        par_addr(a, sel);
        host_rd_n = 1'b0; cyc(10);
        got = host_ad_o; oe_on = host_ad_oe;
        host_rd_n = 1'b1; cyc(6);
        oe_off = host_ad_oe;
        host_dsel = 1'b0; cyc(2);
    endtask

    task automatic put_ser(input bit sck, input bit sd, input bit cs);
        host_ad_i = {sck, sd, cs, 5'b0};
    endtask

    task automatic ser_frame(input bit rw, input logic [6:0] a, input logic [7:0] d, input int nbits,
                             output logic [7:0] got, output bit oe_ok);
        logic [15:0] fr;
        fr = {rw, a, d};
        got = 8'h00; oe_ok = 1'b1;
        put_ser(1'b0, 1'b0, 1'b0); cyc(H);
        for (int i = 0; i < nbits; i++) begin
            put_ser(1'b0, fr[15-i], 1'b0); cyc(H);
            if (i >= 8) begin
                got[15-i] = host_ad_o[6];
                if (rw && host_ad_oe != 8'h40) oe_ok = 1'b0;
            end
            put_ser(1'b1, fr[15-i], 1'b0); cyc(H);
        end
        put_ser(1'b0, 1'b0, 1'b0); cyc(H);
        put_ser(1'b0, 1'b0, 1'b1); cyc(2 * H);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, oe1, oe0;
        bit ok;
        int w0;

        // R12 reset state
        do_reset(1'b0);
        chk(host_ad_oe == 8'h00 && !reg_we && !reg_re, "R12 outputs idle after reset",
            {host_ad_oe, 7'b0, reg_we}, 0);

        // R1 strap changed after reset: the block stays in parallel mode
        cfg_serial = 1'b1;
        par_write(8'h5C, 8'hA7, 1'b1);
        chk(mem[8'h5C] == 8'hA7, "R1 mode held after strap change", mem[8'h5C], 8'hA7);

        // R2 R3 parallel write sweep
        for (int a = 0; a < 256; a++) begin
            par_write(8'(a), pexp(a), 1'b1);
            chk(mem[a] == pexp(a), "R2 R3 parallel write", mem[a], pexp(a));
        end
        // R5 parallel read sweep
        for (int a = 0; a < 256; a++) begin
            par_read(8'(a), 1'b1, got, oe1, oe0);
            chk(got == pexp(a) && oe1 == 8'hFF && oe0 == 8'h00, "R5 parallel read",
                {got, oe1, oe0}, {pexp(a), 8'hFF, 8'h00});
        end

        // R4 disqualified cycles
        w0 = wcnt;
        par_write(8'h10, 8'hEE, 1'b0);
        chk(wcnt == w0 && mem[8'h10] == pexp(16), "R4 write without select", mem[8'h10], pexp(16));
        par_read(8'h11, 1'b0, got, oe1, oe0);
        chk(oe1 == 8'h00, "R4 read without select leaves bus alone", oe1, 0);

        // R1 serial selected at next reset
        do_reset(1'b1);
        chk(host_ad_oe == 8'h00 && !reg_we, "R12 outputs idle after second reset", host_ad_oe, 0);

        // R6 R7 serial write sweep
        for (int a = 0; a < 128; a++) begin
            ser_frame(1'b0, 7'(a), sexp(a), 16, got, ok);
            chk(mem[a] == sexp(a), "R6 R7 serial write", mem[a], sexp(a));
        end
        // R6 R8 serial read sweep
        for (int a = 0; a < 128; a++) begin
            ser_frame(1'b1, 7'(a), 8'h00, 16, got, ok);
            chk(got == sexp(a) && ok && host_ad_oe == 8'h00, "R6 R8 serial read",
                {got, host_ad_oe}, {sexp(a), 8'h00});
        end

        // R9 abandoned frame, then a complete one
        w0 = wcnt;
        ser_frame(1'b0, 7'h05, 8'h99, 12, got, ok);
        chk(wcnt == w0 && mem[5] == sexp(5), "R9 abort without write", mem[5], sexp(5));
        ser_frame(1'b0, 7'h05, 8'h99, 16, got, ok);
        chk(mem[5] == 8'h99, "R9 frame after abort", mem[5], 8'h99);

        // R10 parallel strobes in serial mode (bit 5 kept high so chip select stays idle)
        w0 = wcnt;
        par_write(8'h3C, 8'hE5, 1'b1);
        chk(wcnt == w0, "R10 no write from parallel strobes", wcnt - w0, 0);
        par_read(8'h3C, 1'b1, got, oe1, oe0);
        chk(oe1 == 8'h00, "R10 no drive from parallel read", oe1, 0);
        host_ad_i = 8'h20;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule